// File: doc/BRIEF.md
# Power-Gating Sequence Controller

This block steps a single switchable power domain into and out of its gated state. A sleep request, accepted while the domain is running, starts an entry sequence. The sequence stops the domain clock, can pulse a save strobe so that register contents are copied into storage that stays powered, clamps the domain outputs with isolation, and then opens the power switch. A wake request, accepted while the domain is off, runs the exit sequence in reverse. The exit sequence closes the switch and waits for a power-good acknowledge from it. It can then pulse a restore strobe, after which it releases isolation and runs the clock again.

Every step holds for a settle time that software or a strap sets at run time, so a step lasts `settle_cycles + 1` cycles. A retention-enable input chooses whether the save and restore steps take part. Its value is captured when a sleep request is accepted, so the exit sequence matches the entry sequence that came before it. A sequence is never aborted. A wake request that arrives during entry is remembered and served as soon as the domain is off. Every output comes from a register.

Top module: `pg_seq_ctrl`

## Requirements
- R1: While reset is held and after its release, the block is in the powered state: clk_en=1, pwr_on=1, iso_en=0, save_stb=0, restore_stb=0, busy=0, dom_off=0.
- R2: A sleep_req sampled high in the powered state is accepted at that clock edge. clk_en falls and busy rises in the cycle that follows that edge.
- R3: With retention captured as 1, entry runs in this order: clock gated, one-cycle save_stb, iso_en set, pwr_on cleared. Each step takes L = settle_cycles+1 cycles, and the block reaches the off state (busy=0) 4L cycles after acceptance.
- R4: With retention captured as 0, both save_stb and restore_stb stay low. Entry takes 3L cycles and exit runs without the restore step.
- R5: ret_en is sampled only at the edge that accepts a sleep_req. Later changes to it do not alter the entry sequence in progress or the exit sequence that follows.
- R6: A wake_req sampled high in the off state sets pwr_on in the next cycle. The block then counts L cycles in which pwr_good is sampled high. After that it gives a one-cycle restore_stb (retention only), then clears iso_en, and sets clk_en last, with each step lasting L cycles.
- R7: A wake_req sampled during entry is held. The exit sequence starts at the first edge after the off state is reached, with no new wake_req.
- R8: wake_req in the powered state, sleep_req in the off state and sleep_req during an exit sequence are all ignored. The outputs do not change.
- R9: save_stb and restore_stb are each one cycle wide. They are never high together, and neither is high while pwr_on=0.
- R10: busy is high from the cycle after acceptance until a sequence ends. dom_off is high exactly while pwr_on=0.
- R11: iso_en rises only while the clock is gated. pwr_on falls only while iso_en=1. clk_en rises only when iso_en=0 and pwr_on=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter the gated state |
| wake_req | input | 1 | Request to leave the gated state |
| ret_en | input | 1 | 1 = include save and restore steps |
| settle_cycles | input | CW | Extra cycles held in each step |
| pwr_good | input | 1 | Power-good acknowledge from the switch |
| clk_en | output | 1 | Domain clock enable, 1 = running |
| save_stb | output | 1 | One-cycle retention save pulse |
| restore_stb | output | 1 | One-cycle retention restore pulse |
| iso_en | output | 1 | Output isolation clamp enable |
| pwr_on | output | 1 | Power switch enable, 1 = domain supplied |
| busy | output | 1 | A sequence is in progress |
| dom_off | output | 1 | Domain is unpowered |

## Verification
Outputs are registered from the next state, so every output moves in the cycle right after the edge that samples a request. Step k of a sequence starts kL cycles after acceptance. The exit timing is shifted by the number of cycles the bench holds pwr_good low. The bench counts the cycles from the accepting edge and compares all seven outputs at each falling edge against a step table indexed by cycle/L. It therefore checks each transition in its exact cycle and each strobe for a width of exactly one.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

  typedef enum logic [3:0] {
    ST_ON,       // powered, clocked, idle
    ST_GATE,     // clock stopped
    ST_SAVE,     // retention save
    ST_ISO,      // outputs clamped
    ST_PDN,      // switch opened
    ST_OFF,      // gated, idle
    ST_PUP,      // switch closed, waiting for power-good
    ST_RESTORE,  // retention restore
    ST_UNISO,    // clamp released
    ST_UNGATE    // clock running again
  } pg_state_e;

  typedef struct packed {
    logic clk_en;
    logic iso_en;
    logic pwr_on;
  } pg_rails_t;

  function automatic pg_rails_t rails_of(pg_state_e s);
    pg_rails_t r;
    unique case (s)
      ST_ON, ST_UNGATE:              r = '{clk_en: 1'b1, iso_en: 1'b0, pwr_on: 1'b1};
      ST_GATE, ST_SAVE, ST_UNISO:    r = '{clk_en: 1'b0, iso_en: 1'b0, pwr_on: 1'b1};
      ST_ISO, ST_PUP, ST_RESTORE:    r = '{clk_en: 1'b0, iso_en: 1'b1, pwr_on: 1'b1};
      ST_PDN, ST_OFF:                r = '{clk_en: 1'b0, iso_en: 1'b1, pwr_on: 1'b0};
      default:                       r = '{clk_en: 1'b1, iso_en: 1'b0, pwr_on: 1'b1};
    endcase
    return r;
  endfunction

  function automatic logic is_idle(pg_state_e s);
    return (s == ST_ON) || (s == ST_OFF);
  endfunction

  function automatic logic is_entry(pg_state_e s);
    return (s == ST_GATE) || (s == ST_SAVE) || (s == ST_ISO) || (s == ST_PDN);
  endfunction

  function automatic pg_state_e step_after(pg_state_e s, logic keep);
    pg_state_e n;
    unique case (s)
      ST_GATE:    n = keep ? ST_SAVE : ST_ISO;
      ST_SAVE:    n = ST_ISO;
      ST_ISO:     n = ST_PDN;
      ST_PDN:     n = ST_OFF;
      ST_PUP:     n = keep ? ST_RESTORE : ST_UNISO;
      ST_RESTORE: n = ST_UNISO;
      ST_UNISO:   n = ST_UNGATE;
      ST_UNGATE:  n = ST_ON;
      default:    n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pg_settle_timer.sv
module pg_settle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pg_step_fsm.sv
module pg_step_fsm
  import pg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      ret_en,
  input  logic      pwr_good,
  input  logic      timer_done,
  output pg_state_e st,
  output pg_state_e nxt,
  output logic      timer_load,
  output logic      timer_tick
);

  logic keep_q;     // retention mode captured at sleep acceptance
  logic wake_pend;  // wake seen during entry
  logic step_over;

  // the power-up step only counts cycles in which the switch reports good
  assign timer_tick = (st == ST_PUP) ? pwr_good : 1'b1;
  assign step_over  = timer_done && timer_tick;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_ON:   if (sleep_req) nxt = ST_GATE;
      ST_OFF:  if (wake_req || wake_pend) nxt = ST_PUP;
      default: if (step_over) nxt = step_after(st, keep_q);
    endcase
  end

  assign timer_load = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ON;
      keep_q    <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_ON && sleep_req) keep_q <= ret_en;
      if (nxt == ST_PUP)                       wake_pend <= 1'b0;
      else if (is_entry(st) && wake_req)       wake_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/pg_out_regs.sv
module pg_out_regs
  import pg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pg_state_e st,
  input  pg_state_e nxt,
  output logic      clk_en,
  output logic      save_stb,
  output logic      restore_stb,
  output logic      iso_en,
  output logic      pwr_on,
  output logic      busy,
  output logic      dom_off
);

  pg_rails_t rails_n;
  assign rails_n = rails_of(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en      <= 1'b1;
      iso_en      <= 1'b0;
      pwr_on      <= 1'b1;
      save_stb    <= 1'b0;
      restore_stb <= 1'b0;
      busy        <= 1'b0;
      dom_off     <= 1'b0;
    end else begin
      clk_en      <= rails_n.clk_en;
      iso_en      <= rails_n.iso_en;
      pwr_on      <= rails_n.pwr_on;
      save_stb    <= (nxt == ST_SAVE)    && (st != ST_SAVE);
      restore_stb <= (nxt == ST_RESTORE) && (st != ST_RESTORE);
      busy        <= !is_idle(nxt);
      dom_off     <= (nxt == ST_PDN) || (nxt == ST_OFF);
    end
  end

endmodule

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          ret_en,
  input  logic [CW-1:0] settle_cycles,
  input  logic          pwr_good,
  output logic          clk_en,
  output logic          save_stb,
  output logic          restore_stb,
  output logic          iso_en,
  output logic          pwr_on,
  output logic          busy,
  output logic          dom_off
);

  pg_state_e st, nxt;
  logic      t_load, t_tick, t_done;

  pg_step_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .ret_en     (ret_en),
    .pwr_good   (pwr_good),
    .timer_done (t_done),
    .st         (st),
    .nxt        (nxt),
    .timer_load (t_load),
    .timer_tick (t_tick)
  );

  pg_settle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (settle_cycles),
    .tick     (t_tick),
    .done     (t_done)
  );

  pg_out_regs u_out (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .nxt         (nxt),
    .clk_en      (clk_en),
    .save_stb    (save_stb),
    .restore_stb (restore_stb),
    .iso_en      (iso_en),
    .pwr_on      (pwr_on),
    .busy        (busy),
    .dom_off     (dom_off)
  );

endmodule

// File: rtl/pg_seq_ctrl_chk.sv
module pg_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic clk_en,
  input logic save_stb,
  input logic restore_stb,
  input logic iso_en,
  input logic pwr_on,
  input logic busy,
  input logic dom_off
);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(save_stb && restore_stb));

  a_r9_strobe_needs_power: assert property (@(posedge clk) disable iff (rst)
    (save_stb || restore_stb) |-> pwr_on);

  a_r9_save_one_cycle: assert property (@(posedge clk) disable iff (rst)
    save_stb |=> !save_stb);

  a_r9_restore_one_cycle: assert property (@(posedge clk) disable iff (rst)
    restore_stb |=> !restore_stb);

  a_r6_restore_after_good: assert property (@(posedge clk) disable iff (rst)
    restore_stb |-> $past(pwr_good));

  a_r11_iso_after_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_en) |-> !clk_en);

  a_r11_off_needs_iso: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_on) |-> (iso_en && !clk_en && busy));

  a_r11_clock_last: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> (!iso_en && pwr_on));

  a_r10_domoff_tracks_switch: assert property (@(posedge clk) disable iff (rst)
    dom_off == !pwr_on);

endmodule

bind pg_seq_ctrl pg_seq_ctrl_chk u_chk (.*);

// File: tb/test_pg_seq_ctrl.sv
module test_pg_seq_ctrl;

  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          sleep_req, wake_req, ret_en, pwr_good;
  logic [CW-1:0] settle_cycles;
  logic          clk_en, save_stb, restore_stb, iso_en, pwr_on, busy, dom_off;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  pg_seq_ctrl #(.CW(CW)) i_pg_seq_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .ret_en(ret_en), .settle_cycles(settle_cycles), .pwr_good(pwr_good),
    .clk_en(clk_en), .save_stb(save_stb), .restore_stb(restore_stb),
    .iso_en(iso_en), .pwr_on(pwr_on), .busy(busy), .dom_off(dom_off)
  );

  // vector order: {clk_en, save_stb, restore_stb, iso_en, pwr_on, busy, dom_off}
  localparam logic [6:0] V_ON  = 7'b1000100;
  localparam logic [6:0] V_OFF = 7'b0001001;

  function automatic logic [6:0] exp_entry(int k, int l, bit r);
    int  n    = r ? 4 : 3;
    int  j    = k / l;
    bit  first = (k % l) == 0;
    int  step;
    if (j >= n) return V_OFF;
    step = (!r && j >= 1) ? j + 1 : j;
    case (step)
      0:       return 7'b0000110;
      1:       return {1'b0, first, 5'b00110};
      2:       return 7'b0001110;
      default: return 7'b0001011;
    endcase
  endfunction

  function automatic logic [6:0] exp_exit(int k, int l, bit r, int g);
    int n = r ? 3 : 2;
    int kk, j, step;
    bit first;
    if (k < g + l) return 7'b0001110;
    kk    = k - g - l;
    j     = kk / l;
    first = (kk % l) == 0;
    if (j >= n) return V_ON;
    step = r ? j : j + 1;
    case (step)
      0:       return {2'b00, first, 4'b1110};
      1:       return 7'b0000110;
      default: return 7'b1000110;
    endcase
  endfunction

  task automatic check(logic [6:0] exp, string tag);
    logic [6:0] got;
    got = {clk_en, save_stb, restore_stb, iso_en, pwr_on, busy, dom_off};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  // starts at a falling edge; returns at the falling edge after the last check
  task automatic run_entry(int s, bit r, bit hold);
    int l    = s + 1;
    int last = hold ? (r ? 4 : 3) * l : (r ? 4 : 3) * l + 2;
    settle_cycles = CW'(s);
    ret_en    = r;
    pwr_good  = 1'b0;
    sleep_req = 1'b1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (k == 0) begin
        sleep_req = 1'b0;
        ret_en    = !r;   // R5: change after acceptance must not matter
      end
      if (hold) check(exp_entry(k, l, r), "R7 entry with wake pending");
      else if (r) check(exp_entry(k, l, r), "R2 R3 R5 R9 R10 entry");
      else        check(exp_entry(k, l, r), "R2 R4 R5 R10 entry");
      wake_req = hold && (k == l);
    end
    wake_req = 1'b0;
  endtask

  task automatic run_exit(int s, bit r, int g, bit drive, bit poke);
    int l = s + 1;
    int last = g + l + (r ? 3 : 2) * l + 2;
    if (drive) wake_req = 1'b1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (k == 0) wake_req = 1'b0;
      if (r) check(exp_exit(k, l, r, g), drive ? "R6 R9 R10 R11 exit" : "R7 exit");
      else   check(exp_exit(k, l, r, g), drive ? "R4 R6 R11 exit"     : "R7 exit");
      if (k == g) pwr_good = 1'b1;
      sleep_req = poke && (k == 1);   // R8: sleep during exit
    end
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, got=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int svals[3] = '{0, 1, 3};
    rst = 1'b1; sleep_req = 1'b0; wake_req = 1'b0; ret_en = 1'b1;
    pwr_good = 1'b1; settle_cycles = '0;
    repeat (3) @(negedge clk);
    check(V_ON, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check(V_ON, "R1 after reset");

    // R8: wake while powered
    wake_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wake_req = 1'b0;
      check(V_ON, "R8 wake in powered state");
    end

    foreach (svals[i]) begin
      for (int r = 0; r < 2; r++) begin
        for (int g = 0; g <= 2; g += 2) begin
          run_entry(svals[i], bit'(r), 1'b0);
          // R8: sleep while off
          sleep_req = 1'b1;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sleep_req = 1'b0;
            check(V_OFF, "R8 sleep in off state");
          end
          run_exit(svals[i], bit'(r), g, 1'b1, g == 2);
        end
      end
    end

    for (int s = 0; s <= 2; s += 2) begin
      for (int r = 0; r < 2; r++) begin
        run_entry(s, bit'(r), 1'b1);
        run_exit(s, bit'(r), 1, 1'b0, 1'b0);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule